// File: doc/BRIEF.md
# Programmable three-port parallel interface

This block is a byte-wide parallel I/O peripheral with three 8-bit ports (A, B and C) and a control register. A CPU configures and accesses it through a small asynchronous-style bus of active-low strobes. The bus signals are sampled on the block clock. A write takes effect on the first clock edge at which the write strobe is seen active. A read returns data combinationally while the read strobe is active, and its side effects take place on the first clock edge after the strobe is released.

Each port can be used as plain latched I/O. Port C is split into an upper and a lower nibble, and each nibble has its own direction. Port B can instead run a strobed handshake. In that mode the three low port C lines are taken over for the strobe or acknowledge input, the buffer flag and the interrupt request. The control address accepts two command forms, and bit 7 selects between them. One form is a full configuration word. The other sets or clears a single port C line.

Top module: `ppi_core`

## Requirements
- R1: After reset every port is an input (all output enables low), all output latches read zero, port B is in simple mode and all handshake flags and the interrupt enable are clear.
- R2: Address 0 selects port A, 1 port B, 2 port C and 3 control. A port write is held in its output latch until the next write or configuration word. The latch drives its pins only while the port is an output.
- R3: A control write with bit 7 = 1 is a configuration word, where 1 means input. Bit 4 is the port A direction, bit 3 the upper C direction, bit 1 the port B direction and bit 0 the lower C direction. Bit 2 = 1 selects strobed mode for port B. Bits 6:5 are ignored, and port A is always plain I/O.
- R4: A configuration word clears the A, B and C output latches, the buffer flags, the interrupt request and the interrupt enable.
- R5: A control write with bit 7 = 0 writes bit 0 into port C line number bits 3:1 and leaves the other lines unchanged.
- R6: A read of an input port returns its pins. A read of an output port returns its latch. Port C is resolved per nibble.
- R7: In strobed input mode (bit 2 = 1, bit 1 = 1), a falling edge on pin C2 captures port B's pins and sets the input-full flag on C1 (high = full). A port B read then returns the captured byte even if the pins change.
- R8: In strobed input mode, a completed port B read clears the input-full flag and the interrupt request. The request (C0 high) is raised on the rising edge of C2 when the flag is set and interrupts are enabled.
- R9: In strobed output mode (bit 2 = 1, bit 1 = 0), a port B write drives C1 low (output full) and clears the request. A falling edge on C2 returns C1 high. A rising edge on C2 raises C0 if interrupts are enabled.
- R10: In strobed mode the interrupt enable is written by the bit-control form on line 2. Port C reads return {enable, C1 flag level, request} in bits 2:0. C0 and C1 are outputs and C2 is an input.
- R11: With chip select high, writes have no effect and data_o reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register select |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, zero when not reading |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A latch out |
| pa_oe_o | output | 1 | Port A drive enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B latch out |
| pb_oe_o | output | 1 | Port B drive enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C latch and handshake out |
| pc_oe_o | output | 8 | Port C per-line drive enable |

## Verification
A wrong configuration register shows up at once as a wrong drive enable on the next clock. A wrong latch or flag shows on pa_o, pb_o or the low port C lines one clock after the write or strobe edge that caused it, so the bench compares every output on every clock. A mis-captured strobed byte can only appear through a port B read, so every handshake sequence ends with one. The interrupt enable is likewise visible only through a port C read.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PW = 8;
  localparam int AW = 2;
  localparam int LW = $clog2(PW);
  localparam int HALF = PW / 2;

  typedef enum logic [AW-1:0] {SEL_A = 2'd0, SEL_B = 2'd1, SEL_C = 2'd2, SEL_CTL = 2'd3} sel_e;

  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_strb;
    logic b_in;
    logic cl_in;
  } cfg_t;

  localparam cfg_t CFG_RST = '{a_in: 1'b1, cu_in: 1'b1, b_strb: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_bus_if.sv
module ppi_bus_if
  import ppi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  output logic          wr_go_o,
  output logic          rd_act_o,
  output logic          rd_end_o,
  output sel_e          rd_sel_o
);
  logic acc_wr, acc_rd, wr_q, rd_q;
  sel_e rd_sel_q;

  assign acc_wr = ~cs_ni & ~wr_ni;
  assign acc_rd = ~cs_ni & ~rd_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      rd_sel_q <= SEL_A;
    end else begin
      wr_q <= acc_wr;
      rd_q <= acc_rd;
      if (acc_rd) rd_sel_q <= sel_e'(addr_i);
    end
  end

  assign wr_go_o  = acc_wr & ~wr_q;
  assign rd_act_o = acc_rd;
  assign rd_end_o = rd_q & ~acc_rd;
  assign rd_sel_o = rd_sel_q;
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_go_i,
  input  sel_e          sel_i,
  input  logic [PW-1:0] data_i,
  output cfg_t          cfg_o,
  output logic [PW-1:0] pa_q_o,
  output logic [PW-1:0] pc_q_o,
  output logic          mode_wr_o,
  output logic          inte_wr_o,
  output logic          inte_val_o
);
  logic bsr_wr;
  logic [LW-1:0] bsr_line;

  assign mode_wr_o  = wr_go_i && sel_i == SEL_CTL && data_i[PW-1];
  assign bsr_wr     = wr_go_i && sel_i == SEL_CTL && !data_i[PW-1];
  assign bsr_line   = data_i[LW:1];
  assign inte_wr_o  = bsr_wr && cfg_o.b_strb && bsr_line == LW'(2);
  assign inte_val_o = data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= CFG_RST;
      pa_q_o <= '0;
      pc_q_o <= '0;
    end else if (mode_wr_o) begin
      // bits 6:5 carry no meaning here
      cfg_o  <= '{a_in: data_i[4], cu_in: data_i[3], b_strb: data_i[2],
                  b_in: data_i[1], cl_in: data_i[0]};
      pa_q_o <= '0;
      pc_q_o <= '0;
    end else if (bsr_wr) begin
      pc_q_o[bsr_line] <= data_i[0];
    end else if (wr_go_i && sel_i == SEL_A) begin
      pa_q_o <= data_i;
    end else if (wr_go_i && sel_i == SEL_C) begin
      pc_q_o <= data_i;
    end
  end
endmodule

// File: rtl/ppi_port_b.sv
module ppi_port_b
  import ppi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cfg_t          cfg_i,
  input  logic          wr_go_i,
  input  sel_e          sel_i,
  input  logic [PW-1:0] data_i,
  input  logic          mode_wr_i,
  input  logic          inte_wr_i,
  input  logic          inte_val_i,
  input  logic          rd_end_i,
  input  sel_e          rd_sel_i,
  input  logic [PW-1:0] pb_i,
  input  logic          hs_pin_i,
  output logic [PW-1:0] pb_q_o,
  output logic [PW-1:0] pb_rd_o,
  output logic          ibf_o,
  output logic          obf_o,
  output logic          intr_o,
  output logic          inte_o
);
  logic hs_q, hs_fall, hs_rise, strb_in, strb_out;
  logic [PW-1:0] pb_cap_q;

  assign hs_fall  = hs_q & ~hs_pin_i;
  assign hs_rise  = ~hs_q & hs_pin_i;
  assign strb_in  = cfg_i.b_strb & cfg_i.b_in;
  assign strb_out = cfg_i.b_strb & ~cfg_i.b_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q     <= 1'b1;
      pb_q_o   <= '0;
      pb_cap_q <= '0;
      ibf_o    <= 1'b0;
      obf_o    <= 1'b0;
      intr_o   <= 1'b0;
      inte_o   <= 1'b0;
    end else begin
      hs_q <= hs_pin_i;
      if (mode_wr_i) begin
        pb_q_o   <= '0;
        pb_cap_q <= '0;
        ibf_o    <= 1'b0;
        obf_o    <= 1'b0;
        intr_o   <= 1'b0;
        inte_o   <= 1'b0;
      end else begin
        if (inte_wr_i) inte_o <= inte_val_i;
        if (wr_go_i && sel_i == SEL_B) begin
          pb_q_o <= data_i;
          if (strb_out) begin
            obf_o  <= 1'b1;
            intr_o <= 1'b0;
          end
        end
        if (strb_in) begin
          if (hs_fall) begin
            pb_cap_q <= pb_i;
            ibf_o    <= 1'b1;
          end
          if (hs_rise && ibf_o && inte_o) intr_o <= 1'b1;
          if (rd_end_i && rd_sel_i == SEL_B) begin
            ibf_o  <= 1'b0;
            intr_o <= 1'b0;
          end
        end
        if (strb_out) begin
          if (hs_fall) obf_o <= 1'b0;
          if (hs_rise && inte_o && !obf_o) intr_o <= 1'b1;
        end
      end
    end
  end

  assign pb_rd_o = !cfg_i.b_in ? pb_q_o : (cfg_i.b_strb ? pb_cap_q : pb_i);
endmodule

// File: rtl/ppi_core.sv
module ppi_core
  import ppi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [1:0]    addr_i,
  input  logic [7:0]    data_i,
  output logic [7:0]    data_o,
  input  logic [7:0]    pa_i,
  output logic [7:0]    pa_o,
  output logic          pa_oe_o,
  input  logic [7:0]    pb_i,
  output logic [7:0]    pb_o,
  output logic          pb_oe_o,
  input  logic [7:0]    pc_i,
  output logic [7:0]    pc_o,
  output logic [7:0]    pc_oe_o
);
  logic wr_go, rd_act, rd_end, mode_wr, inte_wr, inte_val;
  logic ibf, obf, intr, inte;
  sel_e rd_sel, sel;
  cfg_t cfg;
  logic [PW-1:0] pa_q, pc_q, pb_rd, pc_rd, pc_in_mask, pc_base_oe;
  logic [2:0] hs_rd, hs_out;

  assign sel = sel_e'(addr_i);

  ppi_bus_if u_bus (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i,
    .wr_go_o(wr_go), .rd_act_o(rd_act), .rd_end_o(rd_end), .rd_sel_o(rd_sel)
  );

  ppi_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_go_i(wr_go), .sel_i(sel), .data_i,
    .cfg_o(cfg), .pa_q_o(pa_q), .pc_q_o(pc_q), .mode_wr_o(mode_wr),
    .inte_wr_o(inte_wr), .inte_val_o(inte_val)
  );

  ppi_port_b u_pb (
    .clk_i, .rst_ni, .cfg_i(cfg), .wr_go_i(wr_go), .sel_i(sel), .data_i,
    .mode_wr_i(mode_wr), .inte_wr_i(inte_wr), .inte_val_i(inte_val),
    .rd_end_i(rd_end), .rd_sel_i(rd_sel), .pb_i, .hs_pin_i(pc_i[2]),
    .pb_q_o(pb_o), .pb_rd_o(pb_rd), .ibf_o(ibf), .obf_o(obf),
    .intr_o(intr), .inte_o(inte)
  );

  // per-line direction and readback, nibble-wise
  for (genvar i = 0; i < PW; i++) begin : g_pc
    if (i >= HALF) begin : g_hi
      assign pc_in_mask[i] = cfg.cu_in;
    end else begin : g_lo
      assign pc_in_mask[i] = cfg.cl_in;
    end
    assign pc_base_oe[i] = ~pc_in_mask[i];
    assign pc_rd[i] = (i < 3 && cfg.b_strb) ? hs_rd[i % 3]
                    : (pc_in_mask[i] ? pc_i[i] : pc_q[i]);
  end

  assign hs_rd  = {inte, (cfg.b_in ? ibf : ~obf), intr};
  assign hs_out = {pc_q[2], (cfg.b_in ? ibf : ~obf), intr};

  assign pa_o    = pa_q;
  assign pa_oe_o = ~cfg.a_in;
  assign pb_oe_o = ~cfg.b_in;
  assign pc_o    = cfg.b_strb ? {pc_q[PW-1:3], hs_out} : pc_q;
  assign pc_oe_o = cfg.b_strb ? {pc_base_oe[PW-1:3], 3'b011} : pc_base_oe;

  always_comb begin
    data_o = '0;
    if (rd_act) begin
      unique case (sel)
        SEL_A:   data_o = cfg.a_in ? pa_i : pa_q;
        SEL_B:   data_o = pb_rd;
        SEL_C:   data_o = pc_rd;
        default: data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ppi_core_chk.sv
module ppi_core_chk
  import ppi_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_go_i,
  input logic [1:0] addr_i,
  input logic [7:0] data_i,
  input logic [7:0] pc_i,
  input logic [7:0] pa_o,
  input logic [7:0] pb_o,
  input logic [7:0] pc_o,
  input cfg_t       cfg_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_latch_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    !wr_go_i |=> $stable(pa_o) && $stable(pb_o));

  p_mode_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    (wr_go_i && addr_i == 2'd3 && data_i[7]) |=> (pa_o == '0 && pb_o == '0 && pc_o[7:3] == '0));

  p_bit_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    (wr_go_i && addr_i == 2'd3 && !data_i[7] && data_i[3:1] >= 3'd3)
      |=> pc_o[$past(data_i[3:1])] == $past(data_i[0]));

  p_in_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    (cfg_i.b_strb && cfg_i.b_in && $fell(pc_i[2]) && !wr_go_i) |=> pc_o[1]);

  p_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    (cfg_i.b_strb && !cfg_i.b_in && $fell(pc_i[2]) && !wr_go_i) |=> pc_o[1]);
endmodule

bind ppi_core ppi_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_go_i(wr_go), .addr_i(addr_i), .data_i(data_i),
  .pc_i(pc_i), .pa_o(pa_o), .pb_o(pb_o), .pc_o(pc_o), .cfg_i(cfg)
);

// File: tb/test_ppi_core.sv
module test_ppi_core;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0, pa_i = 8'h3C, pb_i = 8'h00, pc_i = 8'hC6;
  logic [7:0] data_o, pa_o, pb_o, pc_o, pc_oe_o;
  logic pa_oe_o, pb_oe_o;

  int n_chk = 0, n_fail = 0;
  bit run = 0;

  // reference state
  bit m_ain = 1, m_cuin = 1, m_bstr = 0, m_bin = 1, m_clin = 1;
  bit m_ibf = 0, m_obf = 0, m_intr = 0, m_inte = 0;
  logic [7:0] m_pa = 0, m_pb = 0, m_pc = 0, m_cap = 0;

  always #10 clk = ~clk;

  ppi_core i_ppi_core (
    .clk_i(clk), .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i(addr), .data_i(din),
    .data_o, .pa_i, .pa_o, .pa_oe_o, .pb_i, .pb_o, .pb_oe_o, .pc_i, .pc_o, .pc_oe_o
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_oe();
    logic [7:0] oe = {{4{~m_cuin}}, {4{~m_clin}}};
    if (m_bstr) oe[2:0] = 3'b011;
    return oe;
  endfunction

  function automatic logic [7:0] exp_pc();
    logic [7:0] v = m_pc;
    if (m_bstr) v[1:0] = {(m_bin ? m_ibf : ~m_obf), m_intr};
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    logic [7:0] v;
    case (a)
      2'd0: v = m_ain ? pa_i : m_pa;
      2'd1: v = !m_bin ? m_pb : (m_bstr ? m_cap : pb_i);
      2'd2: begin
        for (int i = 0; i < 8; i++)
          v[i] = ((i >= 4) ? m_cuin : m_clin) ? pc_i[i] : m_pc[i];
        if (m_bstr) v[2:0] = {m_inte, (m_bin ? m_ibf : ~m_obf), m_intr};
      end
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  // every-clock comparison of registered outputs
  always @(negedge clk) if (run) begin
    chk("R1/R3 pa_oe", {7'd0, pa_oe_o}, {7'd0, ~m_ain});
    chk("R1/R3 pb_oe", {7'd0, pb_oe_o}, {7'd0, ~m_bin});
    chk("R3/R10 pc_oe", pc_oe_o, exp_oe());
    chk("R2 pa_o", pa_o, m_pa);
    chk("R2 pb_o", pb_o, m_pb);
    chk("R5/R9 pc_o", pc_o & exp_oe(), exp_pc() & exp_oe());
  end

  task automatic model_write(logic [1:0] a, logic [7:0] d);
    case (a)
      2'd0: m_pa = d;
      2'd1: begin
        m_pb = d;
        if (m_bstr && !m_bin) begin m_obf = 1; m_intr = 0; end
      end
      2'd2: m_pc = d;
      default: if (d[7]) begin
        {m_ain, m_cuin, m_bstr, m_bin, m_clin} = d[4:0];
        m_pa = 0; m_pb = 0; m_pc = 0; m_cap = 0;
        m_ibf = 0; m_obf = 0; m_intr = 0; m_inte = 0;
      end else begin
        m_pc[d[3:1]] = d[0];
        if (m_bstr && d[3:1] == 3'd2) m_inte = d[0];
      end
    endcase
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d, bit sel = 1);
    @(negedge clk); cs_ni = ~sel; wr_ni = 0; addr = a; din = d;
    @(posedge clk); #1 if (sel) model_write(a, d);
    @(negedge clk); cs_ni = 1; wr_ni = 1;
  endtask

  task automatic bus_rd(string tag, logic [1:0] a, bit sel = 1);
    @(negedge clk); cs_ni = ~sel; rd_ni = 0; addr = a;
    @(posedge clk);
    @(negedge clk);
    chk(tag, data_o, sel ? exp_rd(a) : 8'h00);
    cs_ni = 1; rd_ni = 1;
    @(posedge clk); #1 if (sel && a == 2'd1 && m_bstr && m_bin) begin m_ibf = 0; m_intr = 0; end
  endtask

  task automatic strobe(logic [7:0] d);
    @(negedge clk); pb_i = d; pc_i[2] = 0;
    @(posedge clk); #1
    if (m_bstr && m_bin) begin m_cap = d; m_ibf = 1; end
    if (m_bstr && !m_bin) m_obf = 0;
    @(negedge clk); pc_i[2] = 1; pb_i = ~d;
    @(posedge clk); #1
    if (m_bstr && m_bin && m_ibf && m_inte) m_intr = 1;
    if (m_bstr && !m_bin && m_inte && !m_obf) m_intr = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1; run = 1;
    // R1 reset state
    chk("R1 pc_oe after reset", pc_oe_o, 8'h00);
    bus_rd("R1 port C reads pins", 2'd2);
    // R2/R3 all outputs, simple mode
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'h0F);
    repeat (3) @(negedge clk);
    chk("R2 pa latch held", pa_o, 8'h5A);
    bus_rd("R6 port A latch", 2'd0);
    bus_rd("R6 port B latch", 2'd1);
    // R5 bit writes
    bus_wr(2'd3, 8'h0F);
    bus_wr(2'd3, 8'h00);
    bus_rd("R5 bit write", 2'd2);
    chk("R5 pc value", pc_o, 8'h8E);
    // R11 deselected accesses
    bus_wr(2'd0, 8'hFF, 0);
    bus_rd("R11 read without select", 2'd0, 0);
    bus_rd("R11 write ignored", 2'd0);
    // R4/R6 inputs
    bus_wr(2'd3, 8'h9B);
    chk("R4 pa cleared", pa_o, 8'h00);
    pb_i = 8'hA7;
    bus_rd("R6 port A pins", 2'd0);
    bus_rd("R6 port B pins", 2'd1);
    bus_wr(2'd3, 8'h88);
    bus_wr(2'd2, 8'hA5);
    bus_rd("R6 port C mixed nibbles", 2'd2);
    // R3 bits 6:5 ignored
    bus_wr(2'd3, 8'hE0);
    bus_wr(2'd0, 8'h21);
    chk("R3 group A stays plain", {7'd0, pa_oe_o}, 8'h01);
    bus_rd("R3 port A readback", 2'd0);
    // R7/R8/R10 strobed input
    bus_wr(2'd3, 8'h86);
    bus_wr(2'd3, 8'h05);
    bus_rd("R10 enable readback", 2'd2);
    strobe(8'h77);
    chk("R7 input full", {7'd0, pc_o[1]}, 8'h01);
    chk("R8 request raised", {7'd0, pc_o[0]}, 8'h01);
    bus_rd("R7 captured byte", 2'd1);
    bus_rd("R8 flags cleared by read", 2'd2);
    bus_wr(2'd3, 8'h04);
    strobe(8'h3E);
    chk("R10 no request when disabled", {7'd0, pc_o[0]}, 8'h00);
    bus_rd("R7 second capture", 2'd1);
    // R9 strobed output
    bus_wr(2'd3, 8'h84);
    bus_wr(2'd3, 8'h05);
    bus_wr(2'd1, 8'h99);
    chk("R9 output full low", {7'd0, pc_o[1]}, 8'h00);
    strobe(8'h00);
    chk("R9 ack clears full", {7'd0, pc_o[1]}, 8'h01);
    chk("R9 request after ack", {7'd0, pc_o[0]}, 8'h01);
    bus_wr(2'd1, 8'h42);
    chk("R9 write clears request", {7'd0, pc_o[0]}, 8'h00);
    bus_rd("R9 status read", 2'd2);
    // R4 configuration clears pending flags
    bus_wr(2'd3, 8'h84);
    chk("R4 full flag cleared", {7'd0, pc_o[1]}, 8'h01);
    bus_rd("R4 enable cleared", 2'd2);
    repeat (3) @(negedge clk);
    run = 0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule